// File: doc/BRIEF.md
# Memory Region Access Guard

The guard sits in front of a memory port and polices every transaction against eight programmable address windows. Each transaction presents an address, a direction and a one-hot agent identifier. Each enabled window that contains the address consults its read or write permission mask at the agent's bit. If any containing window lacks that bit, the access is denied. A denied write never reaches memory, and a denied read returns all-ones data. The first denial raises a sticky violation flag and a system reset request, and records who did what, where.

Windows are programmed through a small word-indexed register port. Each window has four consecutive registers, and the bounds have 1 KiB granularity. A lock bit freezes a window until system reset. Firmware typically programs the bounds and masks first and sets the lock with a separate, later write. A window holding zero bounds together with the open read and write masks counts as switched off.

Top module: `region_guard`

## Requirements
- R1: After reset every window reads back low 0x00000000, high 0x00000000, read mask 0xBFFFFFFF and write mask 0xFFFFFFFF, is unlocked, and denies nothing. The violation flag and reset request are low.
- R2: Window n occupies register indices 0x40+4n to 0x40+4n+3, in the order low bound, high bound, read mask, write mask. A bound register holds address bits 31:10 in bits 23:2. Bit 31 of the low register is the lock. All other bound bits read as zero. Indices outside 0x40–0x5F read as zero and ignore writes.
- R3: A window covers byte addresses from (low<<8) through (high<<8)+0x3FF inclusive. Addresses one byte outside either end are not covered.
- R4: The agent identifier is one-hot. Bit 0 is the CPU in normal mode, bit 1 the CPU in management mode, bits 8–11 channel 0 sources 0–3, bits 12–15 channel 1 sources 0–3, bit 29 the resource unit, bit 30 dirty snoop and bit 31 the SRAM flush. Within a covering enabled window, a read is allowed only if the agent's bit is set in the read mask, and a write only if it is set in the write mask.
- R5: A window with both bound fields zero, read mask 0xBFFFFFFF and write mask 0xFFFFFFFF never matches. Zero bounds with any other masks form an enabled window over 0x000–0x3FF.
- R6: Windows may overlap, and an access is denied if any covering enabled window denies it.
- R7: The decision appears one clock after the request on rsp_valid_o/rsp_deny_o. An allowed write asserts mem_we_o in that cycle with the request's address and data. A denied write leaves mem_we_o low.
- R8: In the response cycle rd_data_o is 0xFFFFFFFF for a denied access and mem_rdata_i otherwise.
- R9: Writing 1 to bit 31 of an unlocked window's low register locks the window, and this write may follow the earlier programming writes. While locked, writes to all four of that window's registers are ignored until reset.
- R10: The first denial sets viol_o and rst_req_o in the same cycle as rsp_deny_o. It also captures the address, the direction (1 = write), the agent and the lowest denying window index. Later denials change none of these. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational on index) |
| req_valid_i | input | 1 | Transaction present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_agent_i | input | 32 | One-hot source agent |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Decision valid (one cycle after request) |
| rsp_deny_o | output | 1 | Transaction denied |
| mem_we_o | output | 1 | Write enable to memory |
| mem_addr_o | output | 32 | Address to memory |
| mem_wdata_o | output | 32 | Write data to memory |
| mem_rdata_i | input | 32 | Read data from memory in the response cycle |
| rd_data_o | output | 32 | Read data to requester |
| viol_o | output | 1 | Sticky violation flag |
| rst_req_o | output | 1 | Sticky system reset request |
| viol_addr_o | output | 32 | First offending address |
| viol_write_o | output | 1 | First offending direction |
| viol_agent_o | output | 32 | First offending agent |
| viol_win_o | output | 3 | Lowest denying window of first offence |

## Verification
The bench probes the first and last covered byte and the bytes just outside them. A design that drops the implicit +1 KiB on the upper bound would deny nothing at 0x107FF, and one with an off-by-one would deny at 0x10800. The bench also walks one window from the disabled pattern to zero-bound-but-enabled and back. A design that keys "disabled" on zero bounds alone would never deny at 0x200. Overlapping windows with disagreeing masks expose an any-allow merge, and a pair of windows that both deny exposes a captured index that is not the lowest. Lock tests set the lock as a separate later write, then try to rewrite all four registers. A design that freezes too early, or that locks only the low register, shows up in readback and in the access outcome.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned GRAN_W  = 10;               // 1 KiB granularity
  localparam int unsigned FIELD_W = ADDR_W - GRAN_W;  // bound field width
  localparam logic [DATA_W-1:0] RMASK_OFF = 32'hBFFF_FFFF;
  localparam logic [DATA_W-1:0] WMASK_OFF = 32'hFFFF_FFFF;

  typedef struct packed {
    logic              lock;
    logic [FIELD_W-1:0] lo;
    logic [FIELD_W-1:0] hi;
    logic [DATA_W-1:0]  rmask;
    logic [DATA_W-1:0]  wmask;
  } win_cfg_t;

  typedef enum logic [1:0] {
    REG_LO    = 2'd0,
    REG_HI    = 2'd1,
    REG_RMASK = 2'd2,
    REG_WMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/region_guard_regs.sv
module region_guard_regs
  import region_guard_pkg::*;
#(
  parameter int unsigned N_WIN    = 8,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned REG_BASE = 'h40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [CFG_AW-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output win_cfg_t [N_WIN-1:0]    cfg_o
);
  localparam int unsigned IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;
  localparam logic [CFG_AW-1:0] BASE_V = CFG_AW'(REG_BASE);
  localparam logic [CFG_AW-1:0] SPAN_V = CFG_AW'(4 * N_WIN);

  logic [CFG_AW-1:0] rel;
  logic              in_map;
  logic [IDX_W-1:0]  win_sel;
  reg_sel_e          reg_sel;
  win_cfg_t [N_WIN-1:0] cfg_q;

  assign rel     = addr_i - BASE_V;
  assign in_map  = (addr_i >= BASE_V) && (rel < SPAN_V);
  assign win_sel = rel[IDX_W+1:2];
  assign reg_sel = reg_sel_e'(rel[1:0]);

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    logic wr_hit;
    assign wr_hit = wr_i && in_map && (win_sel == IDX_W'(i)) && !cfg_q[i].lock;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '{lock: 1'b0, lo: '0, hi: '0, rmask: RMASK_OFF, wmask: WMASK_OFF};
      end else if (wr_hit) begin
        unique case (reg_sel)
          REG_LO: begin
            cfg_q[i].lock <= wdata_i[DATA_W-1];
            cfg_q[i].lo   <= wdata_i[FIELD_W+1:2];
          end
          REG_HI:    cfg_q[i].hi    <= wdata_i[FIELD_W+1:2];
          REG_RMASK: cfg_q[i].rmask <= wdata_i;
          REG_WMASK: cfg_q[i].wmask <= wdata_i;
          default: ;
        endcase
      end
    end

    assert_lock_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cfg_q[i].lock) |-> ($stable(cfg_q[i]) && cfg_q[i].lock));
  end

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      unique case (reg_sel)
        REG_LO: begin
          rdata_o[DATA_W-1]    = cfg_q[win_sel].lock;
          rdata_o[FIELD_W+1:2] = cfg_q[win_sel].lo;
        end
        REG_HI:    rdata_o[FIELD_W+1:2] = cfg_q[win_sel].hi;
        REG_RMASK: rdata_o = cfg_q[win_sel].rmask;
        REG_WMASK: rdata_o = cfg_q[win_sel].wmask;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/region_guard_win.sv
module region_guard_win
  import region_guard_pkg::*;
(
  input  win_cfg_t           cfg_i,
  input  logic [FIELD_W-1:0] blk_i,    // address bits above the granule
  input  logic               write_i,
  input  logic [DATA_W-1:0]  agent_i,
  output logic               deny_o
);
  logic enabled, hit, allow;

  assign enabled = !((cfg_i.lo == '0) && (cfg_i.hi == '0) &&
                     (cfg_i.rmask == RMASK_OFF) && (cfg_i.wmask == WMASK_OFF));
  assign hit     = (blk_i >= cfg_i.lo) && (blk_i <= cfg_i.hi);
  assign allow   = |((write_i ? cfg_i.wmask : cfg_i.rmask) & agent_i);
  assign deny_o  = enabled && hit && !allow;
endmodule

// File: rtl/region_guard_viol.sv
module region_guard_viol
  import region_guard_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] agent_i,
  input  logic [IDX_W-1:0]  win_i,
  output logic              viol_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [DATA_W-1:0] agent_o,
  output logic [IDX_W-1:0]  win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o  <= 1'b0;
      addr_o  <= '0;
      write_o <= 1'b0;
      agent_o <= '0;
      win_o   <= '0;
    end else if (set_i && !viol_o) begin
      viol_o  <= 1'b1;
      addr_o  <= addr_i;
      write_o <= write_i;
      agent_o <= agent_i;
      win_o   <= win_i;
    end
  end

  assert_viol_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> (viol_o && $stable(addr_o) && $stable(write_o) &&
                $stable(agent_o) && $stable(win_o)));
endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int unsigned N_WIN    = 8,
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned REG_BASE = 'h40,
  localparam int unsigned IDX_W   = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_agent_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_deny_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              viol_o,
  output logic              rst_req_o,
  output logic [ADDR_W-1:0] viol_addr_o,
  output logic              viol_write_o,
  output logic [DATA_W-1:0] viol_agent_o,
  output logic [IDX_W-1:0]  viol_win_o
);
  win_cfg_t [N_WIN-1:0] cfg;
  logic [N_WIN-1:0]     deny_vec;
  logic                 deny_any;
  logic [IDX_W-1:0]     deny_idx;

  region_guard_regs #(.N_WIN(N_WIN), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE)) u_regs (
    .clk_i, .rst_ni,
    .wr_i   (cfg_wr_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .cfg_o  (cfg)
  );

  for (genvar i = 0; i < N_WIN; i++) begin : g_chk
    region_guard_win u_win (
      .cfg_i  (cfg[i]),
      .blk_i  (req_addr_i[ADDR_W-1:GRAN_W]),
      .write_i(req_write_i),
      .agent_i(req_agent_i),
      .deny_o (deny_vec[i])
    );
  end

  assign deny_any = |deny_vec;

  // lowest denying window wins the report
  always_comb begin
    deny_idx = '0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (deny_vec[i]) deny_idx = IDX_W'(i);
    end
  end

  logic              r_valid, r_write, r_deny;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_valid <= 1'b0;
      r_write <= 1'b0;
      r_deny  <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else begin
      r_valid <= req_valid_i;
      r_write <= req_write_i;
      r_deny  <= req_valid_i && deny_any;
      r_addr  <= req_addr_i;
      r_wdata <= req_wdata_i;
    end
  end

  assign rsp_valid_o = r_valid;
  assign rsp_deny_o  = r_deny;
  assign mem_we_o    = r_valid && r_write && !r_deny;
  assign mem_addr_o  = r_addr;
  assign mem_wdata_o = r_wdata;
  assign rd_data_o   = r_deny ? '1 : mem_rdata_i;

  region_guard_viol #(.IDX_W(IDX_W)) u_viol (
    .clk_i, .rst_ni,
    .set_i  (req_valid_i && deny_any),
    .addr_i (req_addr_i),
    .write_i(req_write_i),
    .agent_i(req_agent_i),
    .win_i  (deny_idx),
    .viol_o (viol_o),
    .addr_o (viol_addr_o),
    .write_o(viol_write_o),
    .agent_o(viol_agent_o),
    .win_o  (viol_win_o)
  );
  assign rst_req_o = viol_o;

  assert_agent_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot(req_agent_i));
  assert_deny_blocks_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && deny_any) |=> (rsp_deny_o && !mem_we_o));
  assert_denied_read_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && deny_any) |=> (rd_data_o == '1));
  assert_first_viol_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_o) |-> rsp_deny_o);
endmodule

// File: tb/tb_region_guard.sv
module tb_region_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_agent_i = 32'h1, req_wdata_i = '0;
  logic        rsp_valid_o, rsp_deny_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, rd_data_o;
  logic [31:0] mem_rdata_i = '0;
  logic        viol_o, rst_req_o, viol_write_o;
  logic [31:0] viol_addr_o, viol_agent_o;
  logic [2:0]  viol_win_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  region_guard dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    cfg_addr_i = a;
    #1;
    d = cfg_rdata_o;
  endtask

  // drives one request; returns at the response cycle
  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] ag,
                      input logic [31:0] wd, input logic [31:0] md);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a;
    req_agent_i = ag; req_wdata_i = wd; mem_rdata_i = md;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [31:0] a, input logic [31:0] ag,
                          input logic exp_deny);
    xfer(1'b0, a, ag, '0, 32'h5A5A_0F0F);
    chk({tag, " valid"}, {31'b0, rsp_valid_o}, 32'h1);
    chk({tag, " deny"}, {31'b0, rsp_deny_o}, {31'b0, exp_deny});
    chk({tag, " rdata"}, rd_data_o, exp_deny ? 32'hFFFF_FFFF : 32'h5A5A_0F0F);
  endtask

  task automatic reg_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    cfg_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    reg_check("R1 w0 lo", 8'h40, 32'h0);
    reg_check("R1 w0 hi", 8'h41, 32'h0);
    reg_check("R1 w0 rmask", 8'h42, 32'hBFFF_FFFF);
    reg_check("R1 w7 wmask", 8'h5F, 32'hFFFF_FFFF);
    chk("R1 viol", {31'b0, viol_o}, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req_o}, 32'h0);
    rd_check("R1 open read", 32'h0000_0200, 32'h2, 1'b0);
  endtask

  task automatic t_regmap;
    cfg_wr(8'h40, 32'h7F00_0103);   // reserved bits set, lock clear
    cfg_wr(8'h41, 32'hFF00_0105);
    cfg_wr(8'h42, 32'h1);
    cfg_wr(8'h43, 32'h1);
    reg_check("R2 lo reserved dropped", 8'h40, 32'h0000_0100);
    reg_check("R2 hi reserved dropped", 8'h41, 32'h0000_0104);
    reg_check("R2 rmask", 8'h42, 32'h1);
    cfg_wr(8'h5E, 32'h0000_F00F);
    reg_check("R2 w7 rmask", 8'h5E, 32'h0000_F00F);
    cfg_wr(8'h5E, 32'hBFFF_FFFF);
    cfg_wr(8'h60, 32'h1234_5678);
    reg_check("R2 above map", 8'h60, 32'h0);
    reg_check("R2 below map", 8'h3F, 32'h0);
    reg_check("R2 w0 unchanged", 8'h40, 32'h0000_0100);
  endtask

  task automatic t_first_violation;
    cfg_wr(8'h48, 32'h200); cfg_wr(8'h49, 32'h20C);
    cfg_wr(8'h4A, 32'h1);   cfg_wr(8'h4B, 32'hFFFF_FFFF);
    cfg_wr(8'h54, 32'h200); cfg_wr(8'h55, 32'h20C);
    cfg_wr(8'h56, 32'h1);   cfg_wr(8'h57, 32'hFFFF_FFFF);
    chk("R10 clear before", {31'b0, viol_o}, 32'h0);
    rd_check("R10 first deny", 32'h0002_0800, 32'h100, 1'b1);
    chk("R10 viol", {31'b0, viol_o}, 32'h1);
    chk("R10 rst_req", {31'b0, rst_req_o}, 32'h1);
    chk("R10 addr", viol_addr_o, 32'h0002_0800);
    chk("R10 dir", {31'b0, viol_write_o}, 32'h0);
    chk("R10 agent", viol_agent_o, 32'h100);
    chk("R10 lowest window", {29'b0, viol_win_o}, 32'd2);
  endtask

  task automatic t_range;
    rd_check("R3 below lo", 32'h0000_FFFF, 32'h100, 1'b0);
    rd_check("R3 first byte", 32'h0001_0000, 32'h100, 1'b1);
    rd_check("R3 last byte", 32'h0001_07FF, 32'h100, 1'b1);
    rd_check("R3 above hi", 32'h0001_0800, 32'h100, 1'b0);
  endtask

  task automatic t_mask;
    xfer(1'b1, 32'h0001_0010, 32'h1, 32'hA5A5_0001, '0);
    chk("R7 allowed write we", {31'b0, mem_we_o}, 32'h1);
    chk("R7 allowed write addr", mem_addr_o, 32'h0001_0010);
    chk("R7 allowed write data", mem_wdata_o, 32'hA5A5_0001);
    chk("R4 allowed write deny", {31'b0, rsp_deny_o}, 32'h0);
    xfer(1'b1, 32'h0001_0010, 32'h2, 32'hDEAD_BEEF, '0);
    chk("R7 denied write we", {31'b0, mem_we_o}, 32'h0);
    chk("R4 mgmt-mode write deny", {31'b0, rsp_deny_o}, 32'h1);
    cfg_wr(8'h42, 32'h100);
    xfer(1'b0, 32'h0001_0020, 32'h100, '0, 32'h1234_5678);
    chk("R8 allowed read data", rd_data_o, 32'h1234_5678);
    chk("R4 ch0 read allowed", {31'b0, rsp_deny_o}, 32'h0);
    xfer(1'b0, 32'h0001_0020, 32'h1, '0, 32'h1234_5678);
    chk("R8 denied read ones", rd_data_o, 32'hFFFF_FFFF);
    chk("R4 cpu read denied", {31'b0, rsp_deny_o}, 32'h1);
    chk("R10 addr held", viol_addr_o, 32'h0002_0800);
    chk("R10 dir held", {31'b0, viol_write_o}, 32'h0);
    chk("R10 win held", {29'b0, viol_win_o}, 32'd2);
  endtask

  task automatic t_overlap;
    cfg_wr(8'h4A, 32'h100);   // window 2 now allows channel 0 source 0
    rd_check("R6 one window denies", 32'h0002_0000, 32'h100, 1'b1);
    cfg_wr(8'h56, 32'h101);   // window 5 allows it too
    rd_check("R6 both allow", 32'h0002_0000, 32'h100, 1'b0);
  endtask

  task automatic t_disabled;
    cfg_wr(8'h44, 32'h0); cfg_wr(8'h45, 32'h0);
    rd_check("R5 zero bounds still off", 32'h0000_0200, 32'h2, 1'b0);
    cfg_wr(8'h46, 32'h1);
    rd_check("R5 zero bounds enabled", 32'h0000_0200, 32'h2, 1'b1);
    rd_check("R5 zero window top", 32'h0000_0400, 32'h2, 1'b0);
    cfg_wr(8'h46, 32'hBFFF_FFFF);
    rd_check("R5 pattern disables", 32'h0000_0200, 32'h2, 1'b0);
  endtask

  task automatic t_lock;
    cfg_wr(8'h4C, 32'h300); cfg_wr(8'h4D, 32'h300);
    cfg_wr(8'h4E, 32'h1);   cfg_wr(8'h4F, 32'h1);
    reg_check("R9 unlocked lo", 8'h4C, 32'h0000_0300);
    cfg_wr(8'h4C, 32'h8000_0300);
    reg_check("R9 later lock write taken", 8'h4C, 32'h8000_0300);
    cfg_wr(8'h4D, 32'h400);
    cfg_wr(8'h4E, 32'hFFFF_FFFF);
    cfg_wr(8'h4F, 32'hFFFF_FFFF);
    cfg_wr(8'h4C, 32'h0);
    reg_check("R9 locked lo", 8'h4C, 32'h8000_0300);
    reg_check("R9 locked hi", 8'h4D, 32'h0000_0300);
    reg_check("R9 locked rmask", 8'h4E, 32'h1);
    reg_check("R9 locked wmask", 8'h4F, 32'h1);
    rd_check("R9 locked still denies", 32'h0003_0000, 32'h2, 1'b1);
    rd_check("R9 hi not widened", 32'h0003_0400, 32'h2, 1'b0);
  endtask

  task automatic t_reset_clear;
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R10 viol cleared by reset", {31'b0, viol_o}, 32'h0);
    chk("R10 rst_req cleared", {31'b0, rst_req_o}, 32'h0);
    reg_check("R9 lock gone after reset", 8'h4C, 32'h0);
    reg_check("R1 rmask after reset", 8'h4E, 32'hBFFF_FFFF);
    rd_check("R1 window 3 off", 32'h0003_0000, 32'h2, 1'b0);
    rd_check("R1 window 2 off", 32'h0002_0800, 32'h100, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_regmap();
    t_first_violation();
    t_range();
    t_mask();
    t_overlap();
    t_disabled();
    t_lock();
    t_reset_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule